// File: doc/BRIEF.md
# DDR SDRAM Bank State Tracker

This block sits on the controller side of a four-bank double data rate SDRAM interface and keeps a model of the command state of the memory. Each clock cycle it takes one decoded command with a bank number, plus the clock-enable level. It decides whether the command is legal in the current state. Legal commands move the per-bank and device-level state. Illegal ones are flagged one cycle later and change nothing.

Each bank has its own state machine with countdown timers. These cover the row-to-column delay, the precharge time and the burst that runs before an automatic precharge. A device-level machine tracks power down, active power down, self refresh, the auto refresh sequence and the mode-register load. A built-in interval counter raises a refresh request often enough to spread the required refreshes over the retention period. A scheduler upstream uses the legality flag and the reported states to choose its next command.

Top module: `ddr_bank_tracker`

## Requirements
- R1: While reset is asserted and directly after it, every bank reports precharging (4), the device mode is idle (0), and both flags are low. Each bank reaches idle (0) after T_RP clock edges.
- R2: Command codes are: 0 no-op, 1 mode load, 2 activate, 3 read, 4 write, 5 read with auto-precharge, 6 write with auto-precharge, 7 precharge, 8 burst stop, 9 auto refresh, 10 self refresh entry, 11 self refresh exit. An activate to an idle bank makes it row active (1). An activate to any other bank is illegal.
- R3: A read or write is legal only on a bank that is row active, reading (2) or writing (3), and only from T_RCD edges after its activate. An early read or write, or one sent to an idle bank, is illegal and leaves the state unchanged.
- R4: Read and write on an open bank switch it between reading and writing. A burst stop returns a reading or writing bank to row active. A burst stop on any other bank is illegal.
- R5: A precharge on an open bank sets it to precharging for T_RP edges, then idle. A precharge on an idle bank is legal and has no effect.
- R6: Read or write with auto-precharge holds the bank in reading or writing for BURST_CYC edges. The bank then passes to precharging for T_RP edges and then to idle with no further command. Any command to that bank during the burst is illegal.
- R7: A mode load is legal only when the device mode is idle and all banks are idle. It shows mode set (5) for T_MRD edges and then returns to idle.
- R8: An auto refresh with all banks idle shows auto refresh (4) for T_RFC edges, then idle. With a bank open it is illegal.
- R9: Self refresh entry with all banks idle gives self refresh (3). Only the exit command returns the device to idle. Other commands there are illegal, and the clock-enable level is ignored.
- R10: With the device idle, clock-enable low gives power down (1) if all banks are idle, else active power down (2). Clock-enable high returns the device to idle. A non-no-op command while clock-enable is low or while powered down is illegal.
- R11: refresh_due rises every REF_INTERVAL = CLK_KHZ*REF_MS/REF_COUNT edges after reset (1562 by default). An accepted auto refresh or self refresh entry clears it.
- R12: cmd_illegal is registered: it is high for the one cycle after an illegal command. A no-op is never illegal, and codes 12 to 15 always are.
- R13: A command addressed to one bank leaves the state of every other bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_code | input | 4 | Decoded command, codes as in R2 |
| cmd_bank | input | 2 | Target bank of the command |
| cke | input | 1 | Clock-enable level driven to the memory |
| bank_state | output | 12 | Per-bank state, bank b in bits 3b+2..3b |
| dev_mode | output | 3 | Device-level mode |
| cmd_illegal | output | 1 | Previous command was rejected |
| refresh_due | output | 1 | A refresh should be issued |

## Verification
The properties assume that one command arrives per cycle and that cmd_code and cmd_bank are stable across the sampling edge. They also assume that clock-enable moves only between commands, never in the same cycle as a state-changing command the property reasons about. The directed stimulus drives every input on the falling edge and returns the command to no-op after one cycle. It changes clock-enable only on its own cycles, so each property sees isolated events. The bench waits out each timer with an exact cycle count, so the boundary edges of T_RCD, T_RP, BURST_CYC, T_MRD and T_RFC are observed directly.

// File: rtl/ddr_bank_pkg.sv
package ddr_bank_pkg;

    typedef enum logic [3:0] {
        CMD_NOP = 4'd0,
        CMD_MRS = 4'd1,
        CMD_ACT = 4'd2,
        CMD_RD  = 4'd3,
        CMD_WR  = 4'd4,
        CMD_RDA = 4'd5,
        CMD_WRA = 4'd6,
        CMD_PRE = 4'd7,
        CMD_BST = 4'd8,
        CMD_REF = 4'd9,
        CMD_SRE = 4'd10,
        CMD_SRX = 4'd11
    } cmd_e;

    typedef enum logic [2:0] {
        BK_IDLE  = 3'd0,
        BK_OPEN  = 3'd1,
        BK_READ  = 3'd2,
        BK_WRITE = 3'd3,
        BK_PRECH = 3'd4
    } bank_st_e;

    typedef enum logic [2:0] {
        DM_IDLE   = 3'd0,
        DM_PDN    = 3'd1,
        DM_ACTPDN = 3'd2,
        DM_SELF   = 3'd3,
        DM_AREF   = 3'd4,
        DM_MSET   = 3'd5
    } dev_mode_e;

endpackage

// File: rtl/ddr_bank_fsm.sv
module ddr_bank_fsm
    import ddr_bank_pkg::*;
#(
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int BURST_CYC = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     go,
    input  cmd_e     cmd,
    output bank_st_e state,
    output logic     auto_pre,
    output logic     ready
);
    localparam int MAX_T = (T_RCD > T_RP) ? ((T_RCD > BURST_CYC) ? T_RCD : BURST_CYC)
                                          : ((T_RP > BURST_CYC) ? T_RP : BURST_CYC);
    localparam int CNT_W = $clog2(MAX_T + 1);

    typedef struct packed {
        bank_st_e          st;
        logic              ap;
        logic [CNT_W-1:0]  cnt;
    } bank_reg_t;

    bank_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (go) begin
            unique case (cmd)
                CMD_ACT: begin
                    r_d.st  = BK_OPEN;
                    r_d.ap  = 1'b0;
                    r_d.cnt = CNT_W'(T_RCD - 1);
                end
                CMD_RD:  r_d.st = BK_READ;
                CMD_WR:  r_d.st = BK_WRITE;
                CMD_RDA, CMD_WRA: begin
                    r_d.st  = (cmd == CMD_RDA) ? BK_READ : BK_WRITE;
                    r_d.ap  = 1'b1;
                    r_d.cnt = CNT_W'(BURST_CYC - 1);
                end
                CMD_PRE: begin
                    if (r_q.st inside {BK_OPEN, BK_READ, BK_WRITE}) begin
                        r_d.st  = BK_PRECH;
                        r_d.cnt = CNT_W'(T_RP - 1);
                    end
                end
                CMD_BST: r_d.st = BK_OPEN;
                default: ;
            endcase
        end else begin
            unique case (r_q.st)
                BK_PRECH: begin
                    if (r_q.cnt == '0) r_d.st = BK_IDLE;
                    else               r_d.cnt = r_q.cnt - 1'b1;
                end
                BK_READ, BK_WRITE: begin
                    if (r_q.ap) begin
                        if (r_q.cnt == '0) begin
                            r_d.st  = BK_PRECH;
                            r_d.ap  = 1'b0;
                            r_d.cnt = CNT_W'(T_RP - 1);
                        end else begin
                            r_d.cnt = r_q.cnt - 1'b1;
                        end
                    end
                end
                BK_OPEN: if (r_q.cnt != '0) r_d.cnt = r_q.cnt - 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st  <= BK_PRECH;
            r_q.ap  <= 1'b0;
            r_q.cnt <= CNT_W'(T_RP - 1);
        end else begin
            r_q <= r_d;
        end
    end

    assign state    = r_q.st;
    assign auto_pre = r_q.ap;
    assign ready    = (r_q.cnt == '0);

endmodule

// File: rtl/ddr_cmd_check.sv
module ddr_cmd_check
    import ddr_bank_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  cmd_e                           cmd,
    input  logic [BANK_W-1:0]              bank_sel,
    input  logic                           cke,
    input  dev_mode_e                      mode,
    input  bank_st_e [NUM_BANKS-1:0]       bank_st,
    input  logic [NUM_BANKS-1:0]           bank_ap,
    input  logic [NUM_BANKS-1:0]           bank_rdy,
    output logic                           bank_ok,
    output logic                           dev_ok,
    output logic                           illegal
);
    logic     all_idle;
    bank_st_e tgt_st;
    logic     tgt_ap, tgt_rdy, tgt_open;

    always_comb begin
        all_idle = 1'b1;
        for (int b = 0; b < NUM_BANKS; b++)
            if (bank_st[b] != BK_IDLE) all_idle = 1'b0;
        tgt_st   = bank_st[bank_sel];
        tgt_ap   = bank_ap[bank_sel];
        tgt_rdy  = bank_rdy[bank_sel];
        tgt_open = (tgt_st inside {BK_OPEN, BK_READ, BK_WRITE}) && !tgt_ap;

        bank_ok = 1'b0;
        dev_ok  = 1'b0;
        if (cmd == CMD_NOP) begin
            bank_ok = 1'b0;
        end else if (mode == DM_SELF) begin
            dev_ok = (cmd == CMD_SRX);
        end else if (mode == DM_IDLE && cke) begin
            unique case (cmd)
                CMD_MRS, CMD_REF, CMD_SRE:        dev_ok  = all_idle;
                CMD_ACT:                          bank_ok = (tgt_st == BK_IDLE);
                CMD_RD, CMD_WR, CMD_RDA, CMD_WRA: bank_ok = tgt_open && tgt_rdy;
                CMD_PRE:                          bank_ok = !tgt_ap;
                CMD_BST:                          bank_ok = tgt_open && (tgt_st != BK_OPEN);
                default:                          bank_ok = 1'b0;
            endcase
        end
        illegal = (cmd != CMD_NOP) && !bank_ok && !dev_ok;
    end

endmodule

// File: rtl/ddr_dev_fsm.sv
module ddr_dev_fsm
    import ddr_bank_pkg::*;
#(
    parameter int T_MRD        = 2,
    parameter int T_RFC        = 14,
    parameter int REF_INTERVAL = 1562
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cke,
    input  cmd_e      cmd,
    input  logic      dev_ok,
    input  logic      illegal_in,
    input  logic      any_open,
    output dev_mode_e mode,
    output logic      illegal,
    output logic      refresh_due
);
    localparam int CNT_W = $clog2(((T_MRD > T_RFC) ? T_MRD : T_RFC) + 1);
    localparam int REF_W = $clog2(REF_INTERVAL + 1);

    typedef struct packed {
        dev_mode_e        mode;
        logic [CNT_W-1:0] cnt;
        logic [REF_W-1:0] rcnt;
        logic             due;
        logic             ill;
    } dev_reg_t;

    dev_reg_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.ill = illegal_in;
        unique case (r_q.mode)
            DM_IDLE: begin
                if (dev_ok) begin
                    unique case (cmd)
                        CMD_MRS: begin
                            r_d.mode = DM_MSET;
                            r_d.cnt  = CNT_W'(T_MRD - 1);
                        end
                        CMD_REF: begin
                            r_d.mode = DM_AREF;
                            r_d.cnt  = CNT_W'(T_RFC - 1);
                            r_d.due  = 1'b0;
                        end
                        CMD_SRE: begin
                            r_d.mode = DM_SELF;
                            r_d.due  = 1'b0;
                        end
                        default: ;
                    endcase
                end else if (!cke) begin
                    r_d.mode = any_open ? DM_ACTPDN : DM_PDN;
                end
            end
            DM_PDN, DM_ACTPDN: if (cke) r_d.mode = DM_IDLE;
            DM_SELF:           if (dev_ok) r_d.mode = DM_IDLE;
            DM_AREF, DM_MSET: begin
                if (r_q.cnt == '0) r_d.mode = DM_IDLE;
                else               r_d.cnt  = r_q.cnt - 1'b1;
            end
            default: r_d.mode = DM_IDLE;
        endcase

        if (r_q.rcnt == '0) begin
            r_d.rcnt = REF_W'(REF_INTERVAL - 1);
            r_d.due  = 1'b1;
        end else begin
            r_d.rcnt = r_q.rcnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.mode <= DM_IDLE;
            r_q.cnt  <= '0;
            r_q.rcnt <= REF_W'(REF_INTERVAL - 1);
            r_q.due  <= 1'b0;
            r_q.ill  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mode        = r_q.mode;
    assign illegal     = r_q.ill;
    assign refresh_due = r_q.due;

endmodule

// File: rtl/ddr_bank_tracker.sv
module ddr_bank_tracker
    import ddr_bank_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int BURST_CYC = 2,
    parameter int T_MRD     = 2,
    parameter int T_RFC     = 14,
    parameter int CLK_KHZ   = 200000,
    parameter int REF_MS    = 32,
    parameter int REF_COUNT = 4096,
    localparam int BANK_W       = $clog2(NUM_BANKS),
    localparam int REF_INTERVAL = (CLK_KHZ * REF_MS) / REF_COUNT
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [3:0]             cmd_code,
    input  logic [BANK_W-1:0]      cmd_bank,
    input  logic                   cke,
    output logic [NUM_BANKS*3-1:0] bank_state,
    output logic [2:0]             dev_mode,
    output logic                   cmd_illegal,
    output logic                   refresh_due
);
    cmd_e                     cmd;
    bank_st_e [NUM_BANKS-1:0] st;
    logic [NUM_BANKS-1:0]     ap, rdy, go;
    logic                     bank_ok, dev_ok, illegal_now, any_open;
    dev_mode_e                mode;

    assign cmd = cmd_e'(cmd_code);

    ddr_cmd_check #(.NUM_BANKS(NUM_BANKS)) check_i (
        .cmd      (cmd),
        .bank_sel (cmd_bank),
        .cke      (cke),
        .mode     (mode),
        .bank_st  (st),
        .bank_ap  (ap),
        .bank_rdy (rdy),
        .bank_ok  (bank_ok),
        .dev_ok   (dev_ok),
        .illegal  (illegal_now)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        assign go[g] = bank_ok && (cmd_bank == BANK_W'(g));
        ddr_bank_fsm #(.T_RCD(T_RCD), .T_RP(T_RP), .BURST_CYC(BURST_CYC)) bank_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .go       (go[g]),
            .cmd      (cmd),
            .state    (st[g]),
            .auto_pre (ap[g]),
            .ready    (rdy[g])
        );
        assign bank_state[3*g +: 3] = st[g];
    end

    always_comb begin
        any_open = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++)
            if (st[b] != BK_IDLE) any_open = 1'b1;
    end

    ddr_dev_fsm #(.T_MRD(T_MRD), .T_RFC(T_RFC), .REF_INTERVAL(REF_INTERVAL)) dev_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cke         (cke),
        .cmd         (cmd),
        .dev_ok      (dev_ok),
        .illegal_in  (illegal_now),
        .any_open    (any_open),
        .mode        (mode),
        .illegal     (cmd_illegal),
        .refresh_due (refresh_due)
    );

    assign dev_mode = mode;

endmodule

// File: rtl/ddr_bank_tracker_chk.sv
module ddr_bank_tracker_chk #(
    parameter int NUM_BANKS = 4,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [3:0]             cmd_code,
    input logic [BANK_W-1:0]      cmd_bank,
    input logic                   cke,
    input logic [NUM_BANKS*3-1:0] bank_state,
    input logic [2:0]             dev_mode,
    input logic                   cmd_illegal,
    input logic                   refresh_due
);
    logic [2:0] tgt;
    assign tgt = bank_state[3*cmd_bank +: 3];

    // R2: activate to a bank that is not idle is rejected
    p_act_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_code == 4'd2 && tgt != 3'd0) |=> cmd_illegal);

    // R5: a precharging bank only stays or becomes idle
    p_prech_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_state[2:0] == 3'd4) |=> (bank_state[2:0] == 3'd4 || bank_state[2:0] == 3'd0));

    // R7: mode load with a bank not idle is rejected
    p_mrs_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_code == 4'd1 && bank_state != '0) |=> cmd_illegal);

    // R9: only the exit command leaves self refresh
    p_self_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_mode == 3'd3 && cmd_code != 4'd11) |=> dev_mode == 3'd3);

    // R10: clock-enable high leaves power down
    p_pdn_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((dev_mode == 3'd1 || dev_mode == 3'd2) && cke) |=> dev_mode == 3'd0);

    // R11: the refresh request holds until a refresh is issued
    p_due_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_due && cmd_code != 4'd9 && cmd_code != 4'd10) |=> refresh_due);

    // R12: a no-op never produces the illegal flag
    p_nop_ok_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_code == 4'd0) |=> !cmd_illegal);

endmodule

bind ddr_bank_tracker ddr_bank_tracker_chk #(.NUM_BANKS(NUM_BANKS)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_code    (cmd_code),
    .cmd_bank    (cmd_bank),
    .cke         (cke),
    .bank_state  (bank_state),
    .dev_mode    (dev_mode),
    .cmd_illegal (cmd_illegal),
    .refresh_due (refresh_due)
);

// File: tb/ddr_bank_tracker_tb_top.sv
module ddr_bank_tracker_tb_top;
    localparam int NB     = 4;
    localparam int T_RCD  = 3;
    localparam int T_RP   = 3;
    localparam int BURST  = 2;
    localparam int T_MRD  = 2;
    localparam int T_RFC  = 14;
    localparam int REF_IV = (200000 * 32) / 4096;

    localparam logic [3:0] NOP = 0, MRS = 1, ACT = 2, RD = 3, WR = 4, RDA = 5,
                           WRA = 6, PRE = 7, BST = 8, REF = 9, SRE = 10, SRX = 11;
    localparam logic [2:0] IDLE = 0, OPEN = 1, READ = 2, WRITE = 3, PRECH = 4;
    localparam logic [2:0] M_IDLE = 0, M_PDN = 1, M_APDN = 2, M_SELF = 3, M_AREF = 4, M_MSET = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [3:0]       cmd_code = '0;
    logic [1:0]       cmd_bank = '0;
    logic             cke = 1'b1;
    logic [NB*3-1:0]  bank_state;
    logic [2:0]       dev_mode;
    logic             cmd_illegal;
    logic             refresh_due;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    ddr_bank_tracker dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_code(cmd_code), .cmd_bank(cmd_bank), .cke(cke),
        .bank_state(bank_state), .dev_mode(dev_mode), .cmd_illegal(cmd_illegal),
        .refresh_due(refresh_due)
    );

    function automatic logic [2:0] bst(input int b);
        return bank_state[3*b +: 3];
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_cmd(input logic [3:0] c, input logic [1:0] b);
        cmd_code = c;
        cmd_bank = b;
        @(negedge clk);
        cmd_code = NOP;
        cmd_bank = '0;
    endtask

    task automatic t_reset_refresh();
        check("R1 bank0 after reset", bst(0), PRECH);
        check("R1 bank3 after reset", bst(3), PRECH);
        check("R1 mode after reset", dev_mode, M_IDLE);
        check("R1 illegal after reset", cmd_illegal, 0);
        wait_cyc(T_RP - 1);
        check("R1 bank2 still precharging", bst(2), PRECH);
        wait_cyc(1);
        check("R1 banks idle", bank_state, 0);
        wait_cyc(REF_IV - 1 - T_RP);
        check("R11 due low before interval", refresh_due, 0);
        wait_cyc(1);
        check("R11 due at interval", refresh_due, 1);
        do_cmd(REF, 0);
        check("R11 due cleared by refresh", refresh_due, 0);
        check("R8 auto refresh mode", dev_mode, M_AREF);
        wait_cyc(T_RFC - 1);
        check("R8 still auto refresh", dev_mode, M_AREF);
        wait_cyc(1);
        check("R8 back to idle", dev_mode, M_IDLE);
    endtask

    task automatic t_act_rw();
        do_cmd(RD, 0);
        check("R3 read idle bank illegal", cmd_illegal, 1);
        check("R3 idle bank unchanged", bst(0), IDLE);
        do_cmd(ACT, 0);
        check("R2 activate legal", cmd_illegal, 0);
        check("R2 bank open", bst(0), OPEN);
        wait_cyc(T_RCD - 2);
        do_cmd(RD, 0);
        check("R3 early read illegal", cmd_illegal, 1);
        check("R3 early read no change", bst(0), OPEN);
        do_cmd(RD, 0);
        check("R3 read after tRCD legal", cmd_illegal, 0);
        check("R3 reading", bst(0), READ);
        do_cmd(WR, 0);
        check("R4 read to write", bst(0), WRITE);
        do_cmd(ACT, 0);
        check("R2 activate open bank illegal", cmd_illegal, 1);
        check("R2 open bank unchanged", bst(0), WRITE);
        do_cmd(ACT, 1);
        check("R13 bank1 opened", bst(1), OPEN);
        check("R13 bank0 untouched", bst(0), WRITE);
        do_cmd(BST, 0);
        check("R4 burst stop to open", bst(0), OPEN);
        do_cmd(BST, 0);
        check("R4 burst stop on open bank illegal", cmd_illegal, 1);
    endtask

    task automatic t_precharge();
        do_cmd(PRE, 0);
        check("R5 precharging", bst(0), PRECH);
        wait_cyc(T_RP - 1);
        check("R5 precharging held", bst(0), PRECH);
        wait_cyc(1);
        check("R5 idle after tRP", bst(0), IDLE);
        check("R13 bank1 still open", bst(1), OPEN);
        do_cmd(PRE, 2);
        check("R5 precharge idle bank legal", cmd_illegal, 0);
        check("R5 idle bank unchanged", bst(2), IDLE);
        do_cmd(PRE, 1);
        wait_cyc(T_RP);
        check("R5 bank1 idle", bst(1), IDLE);
    endtask

    task automatic t_mode_load();
        do_cmd(ACT, 3);
        do_cmd(MRS, 0);
        check("R7 mode load with open bank illegal", cmd_illegal, 1);
        check("R7 mode unchanged", dev_mode, M_IDLE);
        do_cmd(REF, 0);
        check("R8 refresh with open bank illegal", cmd_illegal, 1);
        do_cmd(PRE, 3);
        wait_cyc(T_RP);
        do_cmd(MRS, 0);
        check("R7 mode set", dev_mode, M_MSET);
        do_cmd(ACT, 0);
        check("R7 command during mode set illegal", cmd_illegal, 1);
        check("R7 mode set held", dev_mode, M_MSET);
        wait_cyc(T_MRD - 1);
        check("R7 idle after tMRD", dev_mode, M_IDLE);
        check("R7 bank0 idle", bst(0), IDLE);
    endtask

    task automatic t_auto_pre();
        do_cmd(ACT, 0);
        wait_cyc(T_RCD - 1);
        do_cmd(RDA, 0);
        check("R6 read auto-precharge legal", cmd_illegal, 0);
        check("R6 reading", bst(0), READ);
        do_cmd(RD, 0);
        check("R6 command during burst illegal", cmd_illegal, 1);
        check("R6 still reading", bst(0), READ);
        wait_cyc(BURST - 1);
        check("R6 auto precharge", bst(0), PRECH);
        wait_cyc(T_RP - 1);
        check("R6 still precharging", bst(0), PRECH);
        wait_cyc(1);
        check("R6 idle", bst(0), IDLE);
        do_cmd(ACT, 1);
        wait_cyc(T_RCD - 1);
        do_cmd(WRA, 1);
        check("R6 writing", bst(1), WRITE);
        wait_cyc(BURST);
        check("R6 write auto precharge", bst(1), PRECH);
        wait_cyc(T_RP);
        check("R6 write path idle", bst(1), IDLE);
    endtask

    task automatic t_self_ref();
        do_cmd(SRE, 0);
        check("R9 self refresh", dev_mode, M_SELF);
        cke = 1'b0;
        wait_cyc(2);
        check("R9 cke ignored", dev_mode, M_SELF);
        cke = 1'b1;
        do_cmd(ACT, 0);
        check("R9 command in self refresh illegal", cmd_illegal, 1);
        check("R9 bank untouched", bst(0), IDLE);
        do_cmd(SRX, 0);
        check("R9 exit to idle", dev_mode, M_IDLE);
        do_cmd(SRX, 0);
        check("R9 exit while idle illegal", cmd_illegal, 1);
    endtask

    task automatic t_power_down();
        cke = 1'b0;
        wait_cyc(1);
        check("R10 power down", dev_mode, M_PDN);
        do_cmd(ACT, 0);
        check("R10 command in power down illegal", cmd_illegal, 1);
        check("R10 bank untouched", bst(0), IDLE);
        cke = 1'b1;
        wait_cyc(1);
        check("R10 power down exit", dev_mode, M_IDLE);
        do_cmd(ACT, 2);
        cke = 1'b0;
        wait_cyc(1);
        check("R10 active power down", dev_mode, M_APDN);
        cke = 1'b1;
        wait_cyc(1);
        check("R10 active power down exit", dev_mode, M_IDLE);
        check("R10 bank2 kept open", bst(2), OPEN);
        do_cmd(PRE, 2);
        wait_cyc(T_RP);
    endtask

    task automatic t_codes();
        do_cmd(4'd13, 0);
        check("R12 reserved code illegal", cmd_illegal, 1);
        wait_cyc(1);
        check("R12 flag lasts one cycle", cmd_illegal, 0);
        do_cmd(NOP, 0);
        check("R12 no-op legal", cmd_illegal, 0);
        check("R12 banks unchanged", bank_state, 0);
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        t_reset_refresh();
        t_act_rw();
        t_precharge();
        t_mode_load();
        t_auto_pre();
        t_self_ref();
        t_power_down();
        t_codes();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule